// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block owns the 7-bit attenuation code that drives a digital step attenuator core. The code is binary in quarter-decibel units: bit 0 weighs 0.25 dB, bit 1 weighs 0.5 dB, and so on up to bit 6, which weighs 16 dB. A code of 0 is the reference insertion-loss state, and a code of 127 is the 31.75 dB maximum. The block chooses where the code comes from. It can take the seven parallel control pins, either transparently or captured by a latch strobe. It can also take a word delivered by a separate serial receiver together with a one-cycle valid strobe.

The mode select, the latch line and the seven pins are asynchronous board-level inputs. Each one passes through its own two-flop synchronizer before any decision is made. After the synchronous power-on reset the output sits at maximum attenuation. In transparent parallel mode a cycle counter, sized by the `PUP_CYCLES` parameter (400 us at 200 MHz by default), keeps the output at maximum before the preset pins take over. In latched-parallel and serial mode the output stays at maximum until the first word is loaded. The source can be switched between parallel and serial at any time afterwards.

Top module: `atten_ctrl_latch`

## Requirements
- R1: While the reset is asserted, and on the first cycle after it is released, `atten_code_o` is 127 (all ones, 31.75 dB).
- R2: In parallel mode (`ser_sel_i` = 0) with `latch_en_i` high and the power-up delay complete, `atten_code_o` equals `par_code_i` three clock edges after the pins change, and it has not yet changed after two edges. The code is binary with bit 0 = 0.25 dB, so 18.25 dB is code 73.
- R3: In parallel mode with `latch_en_i` low, changes on `par_code_i` leave `atten_code_o` unchanged.
- R4: In parallel mode, a high-then-low pulse on `latch_en_i` loads the pin value that was present when the line fell. A pin change made one cycle after the fall is not loaded.
- R5: After reset in transparent parallel mode, `atten_code_o` stays 127 for `PUP_CYCLES` cycles and then follows the pins.
- R6: After reset in latched-parallel or serial mode, `atten_code_o` stays 127 even after the power-up delay has expired, until a latch pulse or a serial word arrives.
- R7: In serial mode (`ser_sel_i` = 1), a cycle with `ser_valid_i` high loads `ser_word_i` into `atten_code_o` on the next edge.
- R8: In serial mode, activity on `par_code_i` and `latch_en_i` leaves `atten_code_o` unchanged, and so does `ser_word_i` while `ser_valid_i` is low.
- R9: After `ser_sel_i` changes at run time, the newly selected source controls the output: a return to transparent parallel follows the pins, and a return to serial accepts strobed words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| ser_sel_i | input | 1 | Source select: 0 parallel pins, 1 serial receiver (asynchronous) |
| par_code_i | input | CODE_W | Parallel attenuation pins, bit 0 = 0.25 dB (asynchronous) |
| latch_en_i | input | 1 | High: transparent; falling edge: capture pins (asynchronous) |
| ser_word_i | input | CODE_W | Attenuation word from the serial receiver (clk domain) |
| ser_valid_i | input | 1 | One-cycle strobe qualifying `ser_word_i` |
| atten_code_o | output | CODE_W | Active attenuation code to the attenuator core |

## Verification
The transparent path is driven with random pin codes and a directed 18.25 dB value. A check one edge before the expected update and one at the update pins down the three-edge synchronizer latency. The latched path mixes random pin churn with LE held low, a capture pulse, and a pin change one cycle after the fall. Together these show whether capture happens at the falling edge, at the rising edge, or transparently. Serial mode receives random words with gaps between strobes, and pin and LE activity is injected to confirm that the parallel source is cut off. The power-up behaviour is repeated from three reset states (transparent, latched, serial) to separate the timed default from the hold-until-programmed default.

// File: rtl/atten_ctrl_latch.sv
module atten_ctrl_latch #(
  parameter int CODE_W     = 7,
  parameter int PUP_CYCLES = 80000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_i,
  input  logic [CODE_W-1:0] par_code_i,
  input  logic              latch_en_i,
  input  logic [CODE_W-1:0] ser_word_i,
  input  logic              ser_valid_i,
  output logic [CODE_W-1:0] atten_code_o
);

  localparam int CNT_W = $clog2(PUP_CYCLES + 1);
  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  logic [1:0]        sel_sy, le_sy;
  logic [CODE_W-1:0] pin_m, pin_s;
  logic              le_prev;
  logic [CNT_W-1:0]  pup_cnt;
  logic [CODE_W-1:0] code_q;

  wire sel_s    = sel_sy[1];
  wire le_s     = le_sy[1];
  wire le_fell  = le_prev & ~le_s;
  wire pup_done = (pup_cnt == CNT_W'(PUP_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_sy  <= '0;
      le_sy   <= '0;
      pin_m   <= '0;
      pin_s   <= '0;
      le_prev <= 1'b0;
    end else begin
      sel_sy  <= {sel_sy[0], ser_sel_i};
      le_sy   <= {le_sy[0], latch_en_i};
      pin_m   <= par_code_i;
      pin_s   <= pin_m;
      le_prev <= le_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            pup_cnt <= '0;
    else if (!pup_done) pup_cnt <= pup_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= MAX_CODE;
    end else if (sel_s) begin
      if (ser_valid_i) code_q <= ser_word_i;
    end else if (le_s) begin
      if (pup_done) code_q <= pin_s;
    end else if (le_fell) begin
      code_q <= pin_s;
    end
  end

  assign atten_code_o = code_q;

  // R2
  direct_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && le_s && pup_done) |=> atten_code_o == $past(pin_s));

  // R3
  latched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && !le_s && !le_fell) |=> $stable(atten_code_o));

  // R4
  latch_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && le_fell) |=> atten_code_o == $past(pin_s));

  // R5
  pup_max_chk: assert property (@(posedge clk) disable iff (rst)
    (!pup_done && !sel_s && le_s && atten_code_o == MAX_CODE) |=> atten_code_o == MAX_CODE);

  // R7
  serial_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_s && ser_valid_i) |=> atten_code_o == $past(ser_word_i));

  // R8
  serial_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_s && !ser_valid_i) |=> $stable(atten_code_o));

endmodule

// File: tb/atten_ctrl_latch_tb_top.sv
module atten_ctrl_latch_tb_top;
  localparam int PUP = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_sel = 1'b0;
  logic [6:0] pins = '0;
  logic       le = 1'b1;
  logic [6:0] sword = '0;
  logic       svalid = 1'b0;
  logic [6:0] atten;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  atten_ctrl_latch #(.CODE_W(7), .PUP_CYCLES(PUP)) dut_i (
    .clk(clk), .rst(rst), .ser_sel_i(ser_sel), .par_code_i(pins),
    .latch_en_i(le), .ser_word_i(sword), .ser_valid_i(svalid),
    .atten_code_o(atten)
  );

  function automatic logic [6:0] db_to_code(input int centi_db);
    return 7'(centi_db / 25);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (atten !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, atten, exp);
    end
  endtask

  task automatic do_reset(input logic sel, input logic le_v, input logic [6:0] p);
    ser_sel = sel; le = le_v; pins = p; svalid = 1'b0;
    rst = 1'b1;
    tick(4);
    check("R1 code max during reset", 7'h7F);
    rst = 1'b0;
    tick(1);
    check("R1 code max after reset release", 7'h7F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] held, v, w;
    void'($urandom(32'd4242));

    // transparent power-up
    do_reset(1'b0, 1'b1, 7'h2A);
    tick(PUP - 6);
    check("R5 max during power-up delay", 7'h7F);
    tick(16);
    check("R5 pins after power-up delay", 7'h2A);

    // transparent follow with latency
    pins = db_to_code(1825);
    tick(2);
    check("R2 not yet updated after two edges", 7'h2A);
    tick(1);
    check("R2 18.25 dB gives code 73", 7'd73);
    for (int i = 0; i < 20; i++) begin
      v = 7'($urandom);
      pins = v;
      tick(3);
      check("R2 random direct follow", v);
    end
    pins = 7'h00; tick(3); check("R2 all zeros", 7'h00);
    pins = 7'h7F; tick(3); check("R2 all ones", 7'h7F);

    // latched mode
    held = 7'h15;
    pins = held; tick(3);
    le = 1'b0; tick(4);
    for (int i = 0; i < 10; i++) begin
      pins = 7'($urandom);
      tick(4);
      check("R3 pins ignored with LE low", held);
    end
    for (int i = 0; i < 6; i++) begin
      v = 7'($urandom);
      pins = v; tick(4);
      le = 1'b1; tick(1);
      le = 1'b0; tick(1);
      pins = ~v; tick(5);
      check("R4 capture at LE fall", v);
      tick(4);
      check("R3 hold after capture", v);
    end

    // latched power-up
    do_reset(1'b0, 1'b0, 7'h33);
    tick(PUP + 10);
    check("R6 latched stays max after delay", 7'h7F);
    le = 1'b1; tick(1); le = 1'b0; tick(5);
    check("R6 first latch loads pins", 7'h33);

    // serial power-up
    do_reset(1'b1, 1'b0, 7'h00);
    tick(PUP + 10);
    check("R6 serial stays max after delay", 7'h7F);
    for (int i = 0; i < 10; i++) begin
      w = 7'($urandom);
      sword = w; svalid = 1'b1; tick(1);
      svalid = 1'b0; sword = ~w;
      check("R7 serial word loaded", w);
      tick(3);
      check("R8 word ignored without strobe", w);
    end
    held = 7'h4C;
    sword = held; svalid = 1'b1; tick(1); svalid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      pins = 7'($urandom);
      le = 1'b1; tick(4); le = 1'b0; tick(4);
      check("R8 pins and LE ignored in serial", held);
    end

    // run-time switching
    v = 7'h61;
    pins = v; le = 1'b1; ser_sel = 1'b0; tick(4);
    check("R9 back to transparent follows pins", v);
    ser_sel = 1'b1; tick(3);
    check("R9 switch to serial keeps code", v);
    sword = 7'h0E; svalid = 1'b1; tick(1); svalid = 1'b0;
    check("R9 serial after switch", 7'h0E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule